// File: doc/BRIEF.md
# Privileged-Mode Trap Sequencer

This block controls entry into the processor's privileged handler mode and the return from it. A single-cycle strobe starts an entry. The strobe carries a fault code, the PC of the current instruction and the handler base register. The block then jumps to a vector: the base address plus a fixed offset for that fault. It records a restart address for the handler. If the processor was running in normal mode, it also switches in a shadow copy of a few integer registers. Bit 0 of every PC is the mode flag, and a value of 1 means handler mode.

A second strobe requests a return from the handler. The block loads the PC from the saved restart address. If the restart address has bit 0 clear, the block switches the shadow copy out and asks the core to check again for pending interrupts. A return that is requested outside handler mode is not executed. It is turned into an unimplemented-opcode entry instead. A combinational query tells the register file whether a given integer register index should be served from the shadow bank.

Top module: `pal_trap_seq`

## Requirements
- R1: While `rst` is high, and after it drops, `pc_o` equals the aligned base plus 0x0001 and `npc_o` equals `pc_o` + 4. `exc_addr_o` is 0, `shadow_o` is 1, and `shadow_err_o` and `recheck_o` are 0.
- R2: One cycle after an accepted entry, `pc_o` equals the aligned base plus the offset for `fault_i`. The aligned base is `pal_base_i` with its low 14 bits cleared. Codes map to offsets as follows:
  - 0 reset 0x0001
  - 1 machine check 0x0401
  - 2 arithmetic 0x0501
  - 3 interrupt 0x0101
  - 4 data-translation miss (normal) 0x0201
  - 5 data-translation miss (handler) 0x0281
  - 6 alignment 0x0301
  - 7 data-translation fault 0x0381
  - 8 data access violation 0x0381
  - 9 instruction-translation miss 0x0181
  - 10 instruction-translation fault 0x0181
  - 11 instruction access violation 0x0081
  - 12 unimplemented opcode 0x0481
  - 13 floating point disabled 0x0581
  - 14 handler call 0x2001
  - 15 integer overflow 0x0501
- R3: After every entry or return, `npc_o` equals `pc_o` + 4.
- R4: On entry, `exc_addr_o` takes `cur_pc_i`. For codes 2, 14 and 15 it takes `cur_pc_i` + 4 instead.
- R5: An interrupt entry (code 3) taken while `cur_pc_i[0]` is 1 leaves `exc_addr_o` unchanged.
- R6: An entry with `cur_pc_i[0]` = 0 sets `shadow_o`. An entry with `cur_pc_i[0]` = 1 leaves `shadow_o` as it was.
- R7: A return with `cur_pc_i[0]` = 1 loads `pc_o` from `exc_addr_o`. If bit 0 of the saved address is 0, the return also clears `shadow_o` and pulses `recheck_o` for one cycle.
- R8: A return with `cur_pc_i[0]` = 0 acts as an entry with code 12.
- R9: If `entry_vld_i` and `rfe_vld_i` are both high in the same cycle, only the entry takes effect.
- R10: `use_shadow_o` is 1 only when `shadow_o` is 1 and `reg_idx_i` is in the range 8 to 14 or equals 25.
- R11: A request to set the shadow state while it is already set, or to clear it while it is already clear, pulses `shadow_err_o` for one cycle and leaves `shadow_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pal_base_i | input | AW | Handler base register (low 14 bits ignored) |
| cur_pc_i | input | AW | PC of the current instruction; bit 0 is the mode flag |
| entry_vld_i | input | 1 | Entry strobe |
| fault_i | input | 4 | Fault code for the entry |
| rfe_vld_i | input | 1 | Return-from-handler strobe |
| reg_idx_i | input | IDX_W | Integer register index to classify |
| pc_o | output | AW | Registered PC after entry or return |
| npc_o | output | AW | Registered next PC |
| exc_addr_o | output | AW | Saved restart address |
| shadow_o | output | 1 | Shadow bank is switched in |
| use_shadow_o | output | 1 | `reg_idx_i` is served from the shadow bank |
| shadow_err_o | output | 1 | Pulse: redundant shadow switch request |
| recheck_o | output | 1 | Pulse: re-check pending interrupts |

## Verification
Entry and return can be strobed in the same cycle. The bench provokes this with random collisions, including returns whose mode bit would make them illegal, and expects only the entry's outcome. A return outside handler mode and a genuine entry share the vector path. The bench therefore also strobes them back to back across both shadow states. It judges the outcome by the vector PC, by the handling of the restart address, and by whether the redundant-switch error pulses.

// File: rtl/pal_trap_pkg.sv
package pal_trap_pkg;

  localparam int VEC_W   = 14;
  localparam int FAULT_W = 4;

  typedef enum logic [FAULT_W-1:0] {
    F_RESET    = 4'd0,
    F_MCHK     = 4'd1,
    F_ARITH    = 4'd2,
    F_INTR     = 4'd3,
    F_DMISS_N  = 4'd4,
    F_DMISS_P  = 4'd5,
    F_ALIGN    = 4'd6,
    F_DFAULT   = 4'd7,
    F_DACV     = 4'd8,
    F_IMISS    = 4'd9,
    F_IFAULT   = 4'd10,
    F_IACV     = 4'd11,
    F_UNIMP    = 4'd12,
    F_FPDIS    = 4'd13,
    F_HCALL    = 4'd14,
    F_OVF      = 4'd15
  } fault_e;

  // Vector offset within the handler region for each fault class
  function automatic logic [VEC_W-1:0] vec_offset(fault_e f);
    logic [VEC_W-1:0] r;
    unique case (f)
      F_RESET:             r = 14'h0001;
      F_IACV:              r = 14'h0081;
      F_INTR:              r = 14'h0101;
      F_IMISS, F_IFAULT:   r = 14'h0181;
      F_DMISS_N:           r = 14'h0201;
      F_DMISS_P:           r = 14'h0281;
      F_ALIGN:             r = 14'h0301;
      F_DFAULT, F_DACV:    r = 14'h0381;
      F_MCHK:              r = 14'h0401;
      F_UNIMP:             r = 14'h0481;
      F_ARITH, F_OVF:      r = 14'h0501;
      F_FPDIS:             r = 14'h0581;
      F_HCALL:             r = 14'h2001;
      default:             r = 14'h0001;
    endcase
    return r;
  endfunction

  // Trap-type classes resume after the causing instruction
  function automatic logic skips_insn(fault_e f);
    return (f == F_ARITH) || (f == F_OVF) || (f == F_HCALL);
  endfunction

endpackage

// File: rtl/pal_vec_lookup.sv
module pal_vec_lookup
  import pal_trap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] pal_base_i,
  input  fault_e        fault_i,
  output logic [AW-1:0] vec_pc_o,
  output logic [AW-1:0] reset_pc_o,
  output logic          skip_o
);

  localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << VEC_W) - 64'd1);

  logic [AW-1:0] base_al;

  always_comb begin
    base_al    = pal_base_i & ~LOW_MASK;
    vec_pc_o   = base_al + AW'(vec_offset(fault_i));
    reset_pc_o = base_al + AW'(vec_offset(F_RESET));
    skip_o     = skips_insn(fault_i);
  end

endmodule

// File: rtl/pal_exc_addr_reg.sv
module pal_exc_addr_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          skip_i,
  input  logic [AW-1:0] cur_pc_i,
  output logic [AW-1:0] exc_addr_o
);

  localparam logic [AW-1:0] INSN_BYTES = AW'(4);

  logic [AW-1:0] exc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_q <= '0;
    end else if (load_i) begin
      exc_q <= skip_i ? (cur_pc_i + INSN_BYTES) : cur_pc_i;
    end
  end

  assign exc_addr_o = exc_q;

  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (exc_addr_o == $past(exc_addr_o)))
    else $error("exc addr changed without load"); // R5

endmodule

// File: rtl/pal_shadow_ctl.sv
module pal_shadow_ctl #(
  parameter int          NREG        = 32,
  parameter logic [NREG-1:0] SHADOW_MASK = NREG'(32'h0200_7F00),
  localparam int         IDX_W       = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_req_i,
  input  logic             clr_req_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  output logic             shadow_o,
  output logic             err_o,
  output logic             use_shadow_o
);

  logic            shadow_q;
  logic            err_q;
  logic [NREG-1:0] sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      err_q <= (set_req_i && shadow_q) || (clr_req_i && !shadow_q);
      if (set_req_i && !shadow_q) begin
        shadow_q <= 1'b1;
      end else if (clr_req_i && shadow_q) begin
        shadow_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    if (SHADOW_MASK[g]) begin : g_on
      assign sel[g] = shadow_q;
    end else begin : g_off
      assign sel[g] = 1'b0;
    end
  end

  assign use_shadow_o = sel[reg_idx_i];
  assign shadow_o     = shadow_q;
  assign err_o        = err_q;

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(set_req_i && clr_req_i))
    else $error("simultaneous set and clear"); // R9

  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (shadow_o == $past(shadow_o)))
    else $error("shadow changed on redundant request"); // R11

  AST_MAIN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !shadow_o |-> !use_shadow_o)
    else $error("redirect while shadow off"); // R10

endmodule

// File: rtl/pal_trap_seq.sv
module pal_trap_seq
  import pal_trap_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    pal_base_i,
  input  logic [AW-1:0]    cur_pc_i,
  input  logic             entry_vld_i,
  input  logic [3:0]       fault_i,
  input  logic             rfe_vld_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    npc_o,
  output logic [AW-1:0]    exc_addr_o,
  output logic             shadow_o,
  output logic             use_shadow_o,
  output logic             shadow_err_o,
  output logic             recheck_o
);

  localparam logic [AW-1:0] INSN_BYTES = AW'(4);

  logic          in_pal;
  logic          rfe_take;
  logic          rfe_bad;
  logic          rfe_ok;
  logic          vec_take;
  fault_e        eff_fault;
  logic [AW-1:0] vec_pc;
  logic [AW-1:0] reset_pc;
  logic          skip;
  logic          exc_load;
  logic          sh_set;
  logic          sh_clr;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] npc_q;
  logic          recheck_q;

  // Entry wins over return; illegal return becomes an unimplemented-opcode entry
  always_comb begin
    in_pal    = cur_pc_i[0];
    rfe_take  = rfe_vld_i && !entry_vld_i;
    rfe_bad   = rfe_take && !in_pal;
    rfe_ok    = rfe_take && in_pal;
    vec_take  = entry_vld_i || rfe_bad;
    eff_fault = entry_vld_i ? fault_e'(fault_i) : F_UNIMP;
    exc_load  = vec_take && !((eff_fault == F_INTR) && in_pal);
    sh_set    = vec_take && !in_pal;
    sh_clr    = rfe_ok && !exc_addr_o[0];
  end

  pal_vec_lookup #(.AW(AW)) u_vec (
    .pal_base_i (pal_base_i),
    .fault_i    (eff_fault),
    .vec_pc_o   (vec_pc),
    .reset_pc_o (reset_pc),
    .skip_o     (skip)
  );

  pal_exc_addr_reg #(.AW(AW)) u_exc (
    .clk        (clk),
    .rst        (rst),
    .load_i     (exc_load),
    .skip_i     (skip),
    .cur_pc_i   (cur_pc_i),
    .exc_addr_o (exc_addr_o)
  );

  pal_shadow_ctl #(.NREG(NREG)) u_shadow (
    .clk          (clk),
    .rst          (rst),
    .set_req_i    (sh_set),
    .clr_req_i    (sh_clr),
    .reg_idx_i    (reg_idx_i),
    .shadow_o     (shadow_o),
    .err_o        (shadow_err_o),
    .use_shadow_o (use_shadow_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= reset_pc;
      npc_q     <= reset_pc + INSN_BYTES;
      recheck_q <= 1'b0;
    end else begin
      recheck_q <= sh_clr;
      if (vec_take) begin
        pc_q  <= vec_pc;
        npc_q <= vec_pc + INSN_BYTES;
      end else if (rfe_ok) begin
        pc_q  <= exc_addr_o;
        npc_q <= exc_addr_o + INSN_BYTES;
      end
    end
  end

  assign pc_o      = pc_q;
  assign npc_o     = npc_q;
  assign recheck_o = recheck_q;

  AST_ENTRY_IN_PAL: assert property (@(posedge clk) disable iff (rst)
    entry_vld_i |=> pc_o[0])
    else $error("vector PC lacks mode bit"); // R2

  AST_INTR_PAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (entry_vld_i && (fault_i == 4'd3) && cur_pc_i[0]) |=> (exc_addr_o == $past(exc_addr_o)))
    else $error("exc addr overwritten by nested interrupt"); // R5

  AST_RFE_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (rfe_vld_i && !entry_vld_i && !cur_pc_i[0]) |=> (pc_o[13:0] == 14'h0481))
    else $error("illegal return not trapped"); // R8

  AST_RECHECK_OFF: assert property (@(posedge clk) disable iff (rst)
    recheck_o |-> !shadow_o)
    else $error("recheck with shadow on"); // R7

  AST_NPC_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(entry_vld_i || rfe_vld_i) |-> (npc_o == pc_o + INSN_BYTES))
    else $error("npc not pc+4"); // R3

endmodule

// File: tb/pal_trap_seq_test.sv
module pal_trap_seq_test;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] pal_base_i;
  logic [AW-1:0] cur_pc_i;
  logic          entry_vld_i;
  logic [3:0]    fault_i;
  logic          rfe_vld_i;
  logic [4:0]    reg_idx_i;
  logic [AW-1:0] pc_o, npc_o, exc_addr_o;
  logic          shadow_o, use_shadow_o, shadow_err_o, recheck_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic done = 1'b0;

  // model state
  logic [AW-1:0] m_pc, m_npc, m_exc;
  logic          m_sh, m_err, m_rck;

  always #5 clk = ~clk;

  pal_trap_seq #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .pal_base_i(pal_base_i), .cur_pc_i(cur_pc_i),
    .entry_vld_i(entry_vld_i), .fault_i(fault_i), .rfe_vld_i(rfe_vld_i),
    .reg_idx_i(reg_idx_i), .pc_o(pc_o), .npc_o(npc_o), .exc_addr_o(exc_addr_o),
    .shadow_o(shadow_o), .use_shadow_o(use_shadow_o),
    .shadow_err_o(shadow_err_o), .recheck_o(recheck_o)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] off_of(input logic [3:0] f);
    case (f)
      4'd0: return 32'h0001;   4'd1: return 32'h0401;
      4'd2: return 32'h0501;   4'd3: return 32'h0101;
      4'd4: return 32'h0201;   4'd5: return 32'h0281;
      4'd6: return 32'h0301;   4'd7: return 32'h0381;
      4'd8: return 32'h0381;   4'd9: return 32'h0181;
      4'd10: return 32'h0181;  4'd11: return 32'h0081;
      4'd12: return 32'h0481;  4'd13: return 32'h0581;
      4'd14: return 32'h2001;  default: return 32'h0501;
    endcase
  endfunction

  function automatic logic [AW-1:0] aligned(input logic [AW-1:0] b);
    return {b[AW-1:14], 14'd0};
  endfunction

  function automatic logic in_set(input int i);
    return (i >= 8 && i <= 14) || i == 25;
  endfunction

  task automatic model_entry(input logic [3:0] f);
    logic pal;
    pal = cur_pc_i[0];
    if (!(f == 4'd3 && pal))
      m_exc = cur_pc_i + ((f == 4'd2 || f == 4'd14 || f == 4'd15) ? 32'd4 : 32'd0);
    if (!pal) begin
      if (m_sh) m_err = 1'b1; else m_sh = 1'b1;
    end
    m_pc  = aligned(pal_base_i) + off_of(f);
    m_npc = m_pc + 32'd4;
  endtask

  // one operation: drive at negedge, model, check at next negedge
  task automatic step(input logic en, input logic rf, input logic [3:0] f,
                      input logic [AW-1:0] cpc, input logic [AW-1:0] base);
    string tpc, texc, tsh;
    logic intr_pal;
    entry_vld_i = en; rfe_vld_i = rf; fault_i = f; cur_pc_i = cpc; pal_base_i = base;
    m_err = 1'b0; m_rck = 1'b0;
    intr_pal = en && f == 4'd3 && cpc[0];
    tpc = "R2"; texc = intr_pal ? "R5" : "R4"; tsh = "R6";
    if (en) begin
      if (rf) tpc = "R9";
      model_entry(f);
    end else if (rf) begin
      if (!cpc[0]) begin
        tpc = "R8";
        model_entry(4'd12);
      end else begin
        tpc = "R7"; tsh = "R7";
        m_pc = m_exc; m_npc = m_exc + 32'd4;
        if (!m_exc[0]) begin
          m_rck = 1'b1;
          if (m_sh) m_sh = 1'b0; else m_err = 1'b1;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    entry_vld_i = 1'b0; rfe_vld_i = 1'b0;
    chk(tpc, pc_o, m_pc);
    chk("R3", npc_o, m_npc);
    chk(texc, exc_addr_o, m_exc);
    chk(tsh, {31'd0, shadow_o}, {31'd0, m_sh});
    chk("R11", {31'd0, shadow_err_o}, {31'd0, m_err});
    chk("R7", {31'd0, recheck_o}, {31'd0, m_rck});
  endtask

  task automatic sweep_idx();
    for (int i = 0; i < 32; i++) begin
      reg_idx_i = 5'(i);
      #1;
      chk("R10", {31'd0, use_shadow_o}, {31'd0, m_sh && in_set(i)});
    end
  endtask

  function automatic logic [AW-1:0] rnd_pc(input logic b0);
    logic [AW-1:0] v;
    v = $urandom;
    return {v[AW-1:2], 1'b0, b0};
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [AW-1:0] base;
    void'($urandom(7));
    base = 32'h8001_2345;
    rst = 1'b1; entry_vld_i = 0; rfe_vld_i = 0; fault_i = 0;
    cur_pc_i = 0; pal_base_i = base; reg_idx_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset state, checked during and after reset
    chk("R1", pc_o, aligned(base) + 32'h1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", pc_o, aligned(base) + 32'h1);
    chk("R1", npc_o, aligned(base) + 32'h5);
    chk("R1", exc_addr_o, 32'h0);
    chk("R1", {31'd0, shadow_o}, 32'd1);
    chk("R1", {31'd0, shadow_err_o}, 32'd0);
    chk("R1", {31'd0, recheck_o}, 32'd0);
    m_pc = aligned(base) + 32'h1; m_npc = m_pc + 4; m_exc = 0; m_sh = 1;
    sweep_idx();

    // every fault code in both modes, each followed by a legal return
    for (int f = 0; f < 16; f++) begin
      for (int p = 0; p < 2; p++) begin
        step(1'b1, 1'b0, 4'(f), rnd_pc(p[0]), base);
        step(1'b0, 1'b1, 4'd0, rnd_pc(1'b1), base);
        step(1'b1, 1'b0, 4'(f), rnd_pc(1'b0), $urandom);
      end
    end

    // shadow off: normal-mode entry, then a legal return to an even address
    step(1'b1, 1'b0, 4'd6, rnd_pc(1'b0), base);
    step(1'b0, 1'b1, 4'd0, rnd_pc(1'b1), base);
    sweep_idx();
    // redundant clear: return again with saved address still even
    step(1'b0, 1'b1, 4'd0, rnd_pc(1'b1), base);
    // illegal return, then collision cases
    step(1'b0, 1'b1, 4'd0, rnd_pc(1'b0), base);
    sweep_idx();
    step(1'b1, 1'b1, 4'd14, rnd_pc(1'b1), base);
    step(1'b1, 1'b1, 4'd3, rnd_pc(1'b0), base);

    // random mix, collisions included
    for (int k = 0; k < 600; k++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[0], r[1], 4'($urandom), rnd_pc(r[2]), (r[3] ? base : $urandom));
      if (k % 50 == 0) sweep_idx();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule